// File: doc/BRIEF.md
# Loopback Ethernet Frame Pattern Checker

This block sits on the receive side of a 64-bit packet interface after a 10G MAC loopback. A companion generator sends one deterministic test frame for every payload length in a sweep. Each frame starts with a fixed address and EtherType header, then carries two fixed payload bytes, then a run of words that each repeat one count byte in all eight lanes. The checker rebuilds the expected frame for the current length and compares every received beat against it. It gives each frame a good or bad verdict.

The checker counts good and bad frames and keeps a sticky error flag. After any verdict it moves to the next length. After a bad frame it ignores beats until the next start-of-packet. Once the frame at the longest length has been judged, it raises a done flag that holds until reset. Cycles with valid low are ignored, both between frames and inside them.

Top module: `frame_loop_checker`

## Requirements
- R1: After reset, goodCount, badCount, errSticky and done are all zero, and the first expected payload length is MIN_LEN.
- R2: The first beat of a frame must have rxSop high, rxEop low, and rxData equal to 0x000001020304 in bits 63:16 with bits 15:0 zero.
- R3: The second beat must have rxSop and rxEop low, and rxData must hold 0x05060708 in bits 63:32, 0x88B5 in bits 31:16 and 0xBEEF in bits 15:0.
- R4: Each further beat carries one byte in all eight lanes. The byte is bits 10:3 of an 11-bit counter that is loaded with length minus 2 and falls by 8 after each such beat.
- R5: The frame's last beat is the one where the counter's bits 10:3 are zero or the counter equals 8. That beat must have rxEop high and rxMod equal to the counter's bits 2:0, where 0 means all eight bytes are valid. rxMod is examined only on that beat. A beat before it with rxEop high, or that beat with rxEop low, makes the frame bad.
- R6: On a last beat with a nonzero byte count m, only the top m byte lanes (starting at bits 63:56) are compared. The lower lanes may hold any value.
- R7: Every verdict, good or bad, raises the expected payload length by one.
- R8: A frame whose every beat matches increments goodCount by exactly one on its last beat.
- R9: A data mismatch, a first beat without rxSop, rxSop on a later beat, an early or late rxEop, or a wrong byte count increments badCount once for that frame and sets errSticky. errSticky then stays set until reset.
- R10: After a bad verdict, all beats are ignored until the next beat with rxSop high, and that beat is checked as a first beat.
- R11: Cycles with rxValid low do not affect checking, either between frames or between beats of a frame.
- R12: done rises once the frame at length MAX_LEN has received a verdict and stays high until reset. Traffic after that changes neither counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| rxValid | input | 1 | Beat valid |
| rxSop | input | 1 | First beat of frame |
| rxEop | input | 1 | Last beat of frame |
| rxMod | input | 3 | Valid byte count of last beat, 0 = eight |
| rxData | input | 64 | Beat data, first byte in bits 63:56 |
| done | output | 1 | Final length judged (sticky) |
| errSticky | output | 1 | At least one bad frame seen |
| goodCount | output | STAT_W | Count of good frames |
| badCount | output | STAT_W | Count of bad frames |

## Verification
The bench builds the block with MIN_LEN 46 and MAX_LEN 66. That gives 21 frame lengths, so the whole sweep up to done fits in a short run. Those lengths take the last-beat byte count through every value from 0 to 7 at least twice, including the case where the frame ends with the counter at 8. A run this short also leaves room to inject every error kind, to insert stall cycles inside frames, and to send traffic after done.

// File: rtl/frame_chk_pkg.sv
package frame_chk_pkg;

  // width of the payload down-counter; the pattern byte is its bits 10:3
  localparam int CNT_BITS = 11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR1,
    ST_BODY,
    ST_SKIP,
    ST_DONE
  } chk_state_e;

  // control -> datapath
  typedef struct packed {
    logic loadCnt;
    logic stepCnt;
    logic advLen;
    logic incGood;
    logic incBad;
  } dp_strobe_t;

  // datapath -> control
  typedef struct packed {
    logic       hdr0Ok;
    logic       hdr1Ok;
    logic       bodyOk;
    logic       bodyLast;
    logic [2:0] bodyMod;
    logic       atFinal;
  } dp_status_t;

endpackage

// File: rtl/frame_chk_datapath.sv
module frame_chk_datapath
  import frame_chk_pkg::*;
#(
  parameter int          MIN_LEN   = 46,
  parameter int          MAX_LEN   = 1500,
  parameter int          STAT_W    = 16,
  parameter logic [47:0] DST_ADDR  = 48'h000001020304,
  parameter logic [15:0] SRC_HI    = 16'h0000,
  parameter logic [31:0] SRC_LO    = 32'h05060708,
  parameter logic [15:0] ETH_TYPE  = 16'h88B5,
  parameter logic [15:0] LEAD_FILL = 16'hBEEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [63:0]       rxData,
  input  dp_strobe_t        strobe,
  output dp_status_t        status,
  output logic [STAT_W-1:0] goodCount,
  output logic [STAT_W-1:0] badCount,
  output logic              errSticky
);

  localparam int LANES = 8;
  localparam logic [CNT_BITS-1:0] LEN_START = CNT_BITS'(MIN_LEN);
  localparam logic [CNT_BITS-1:0] LEN_LAST  = CNT_BITS'(MAX_LEN);
  localparam logic [63:0] HDR0_WORD = {DST_ADDR, SRC_HI};
  localparam logic [63:0] HDR1_WORD = {SRC_LO, ETH_TYPE, LEAD_FILL};

  logic [CNT_BITS-1:0] expLen;
  logic [CNT_BITS-1:0] downCnt;
  logic [7:0]          bodyByte;
  logic                bodyLast;
  logic [2:0]          bodyMod;
  logic [LANES-1:0]    laneOk;

  // expected length and per-frame down-counter
  always_ff @(posedge clk) begin
    if (rst) begin
      expLen  <= LEN_START;
      downCnt <= '0;
    end else begin
      if (strobe.advLen)
        expLen <= expLen + CNT_BITS'(1);
      if (strobe.loadCnt)
        downCnt <= expLen - CNT_BITS'(2);
      else if (strobe.stepCnt)
        downCnt <= downCnt - CNT_BITS'(8);
    end
  end

  assign bodyByte = downCnt[10:3];
  assign bodyLast = (downCnt[10:3] == 8'd0) || (downCnt == CNT_BITS'(8));
  assign bodyMod  = downCnt[2:0];

  // lane compare, lane 0 occupies bits 63:56
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic laneUsed;
    assign laneUsed = !bodyLast || (bodyMod == 3'd0) || (3'(g) < bodyMod);
    assign laneOk[g] = !laneUsed || (rxData[63-8*g -: 8] == bodyByte);
  end

  always_comb begin
    status          = '0;
    status.hdr0Ok   = (rxData == HDR0_WORD);
    status.hdr1Ok   = (rxData == HDR1_WORD);
    status.bodyOk   = &laneOk;
    status.bodyLast = bodyLast;
    status.bodyMod  = bodyMod;
    status.atFinal  = (expLen == LEN_LAST);
  end

  // verdict counters
  always_ff @(posedge clk) begin
    if (rst) begin
      goodCount <= '0;
      badCount  <= '0;
      errSticky <= 1'b0;
    end else begin
      if (strobe.incGood)
        goodCount <= goodCount + STAT_W'(1);
      if (strobe.incBad) begin
        badCount  <= badCount + STAT_W'(1);
        errSticky <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/frame_chk_control.sv
module frame_chk_control
  import frame_chk_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rxValid,
  input  logic       rxSop,
  input  logic       rxEop,
  input  logic [2:0] rxMod,
  input  dp_status_t status,
  output dp_strobe_t strobe,
  output logic       done
);

  chk_state_e state, nextState;
  logic judgeGood, judgeBad;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    judgeGood = 1'b0;
    judgeBad  = 1'b0;
    unique case (state)
      ST_IDLE, ST_SKIP: begin
        if (rxValid) begin
          if (rxSop) begin
            if (status.hdr0Ok && !rxEop) nextState = ST_HDR1;
            else                         judgeBad  = 1'b1;
          end else if (state == ST_IDLE) begin
            judgeBad = 1'b1;
          end
        end
      end
      ST_HDR1: begin
        if (rxValid) begin
          if (!rxSop && !rxEop && status.hdr1Ok) begin
            strobe.loadCnt = 1'b1;
            nextState      = ST_BODY;
          end else begin
            judgeBad = 1'b1;
          end
        end
      end
      ST_BODY: begin
        if (rxValid) begin
          if (status.bodyLast) begin
            if (!rxSop && rxEop && (rxMod == status.bodyMod) && status.bodyOk)
              judgeGood = 1'b1;
            else
              judgeBad = 1'b1;
          end else if (!rxSop && !rxEop && status.bodyOk) begin
            strobe.stepCnt = 1'b1;
          end else begin
            judgeBad = 1'b1;
          end
        end
      end
      ST_DONE: nextState = ST_DONE;
      default: nextState = ST_IDLE;
    endcase

    if (judgeGood || judgeBad) begin
      strobe.advLen  = 1'b1;
      strobe.incGood = judgeGood;
      strobe.incBad  = judgeBad;
      if (status.atFinal) nextState = ST_DONE;
      else if (judgeGood) nextState = ST_IDLE;
      else                nextState = ST_SKIP;
    end
  end

  assign done = (state == ST_DONE);

endmodule

// File: rtl/frame_loop_checker.sv
module frame_loop_checker
  import frame_chk_pkg::*;
#(
  parameter int MIN_LEN = 46,
  parameter int MAX_LEN = 1500,
  parameter int STAT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxValid,
  input  logic              rxSop,
  input  logic              rxEop,
  input  logic [2:0]        rxMod,
  input  logic [63:0]       rxData,
  output logic              done,
  output logic              errSticky,
  output logic [STAT_W-1:0] goodCount,
  output logic [STAT_W-1:0] badCount
);

  dp_strobe_t strobe;
  dp_status_t status;

  frame_chk_control u_control (
    .clk     (clk),
    .rst     (rst),
    .rxValid (rxValid),
    .rxSop   (rxSop),
    .rxEop   (rxEop),
    .rxMod   (rxMod),
    .status  (status),
    .strobe  (strobe),
    .done    (done)
  );

  frame_chk_datapath #(
    .MIN_LEN (MIN_LEN),
    .MAX_LEN (MAX_LEN),
    .STAT_W  (STAT_W)
  ) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .rxData    (rxData),
    .strobe    (strobe),
    .status    (status),
    .goodCount (goodCount),
    .badCount  (badCount),
    .errSticky (errSticky)
  );

endmodule

// File: rtl/frame_chk_props.sv
module frame_chk_props #(
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rxValid,
  input logic              rxEop,
  input logic              done,
  input logic              errSticky,
  input logic [STAT_W-1:0] goodCount,
  input logic [STAT_W-1:0] badCount
);

  a_r12_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    errSticky |=> errSticky);

  a_r9_bad_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (badCount != $past(badCount)) |-> errSticky);

  a_r8_good_on_eop: assert property (@(posedge clk) disable iff (rst)
    (goodCount != $past(goodCount)) |-> $past(rxValid && rxEop));

  a_r7_one_verdict: assert property (@(posedge clk) disable iff (rst)
    (goodCount != $past(goodCount)) |-> (badCount == $past(badCount)));

  a_r12_frozen_after_done: assert property (@(posedge clk) disable iff (rst)
    done |=> ($stable(goodCount) && $stable(badCount)));

endmodule

bind frame_loop_checker frame_chk_props #(.STAT_W(STAT_W)) u_props (
  .clk       (clk),
  .rst       (rst),
  .rxValid   (rxValid),
  .rxEop     (rxEop),
  .done      (done),
  .errSticky (errSticky),
  .goodCount (goodCount),
  .badCount  (badCount)
);

// File: tb/test_frame_loop_checker.sv
module test_frame_loop_checker;

  localparam int MIN_LEN = 46;
  localparam int MAX_LEN = 66;
  localparam int STAT_W  = 16;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              rxValid = 1'b0;
  logic              rxSop = 1'b0;
  logic              rxEop = 1'b0;
  logic [2:0]        rxMod = 3'd0;
  logic [63:0]       rxData = '0;
  logic              done;
  logic              errSticky;
  logic [STAT_W-1:0] goodCount;
  logic [STAT_W-1:0] badCount;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  int expGood = 0;
  int expBad  = 0;

  always #2 clk = ~clk;

  frame_loop_checker #(
    .MIN_LEN (MIN_LEN),
    .MAX_LEN (MAX_LEN),
    .STAT_W  (STAT_W)
  ) i_frame_loop_checker (
    .clk       (clk),
    .rst       (rst),
    .rxValid   (rxValid),
    .rxSop     (rxSop),
    .rxEop     (rxEop),
    .rxMod     (rxMod),
    .rxData    (rxData),
    .done      (done),
    .errSticky (errSticky),
    .goodCount (goodCount),
    .badCount  (badCount)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic beat(input logic sop, input logic eop, input logic [2:0] mod,
                      input logic [63:0] d);
    @(negedge clk);
    rxValid = 1'b1; rxSop = sop; rxEop = eop; rxMod = mod; rxData = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1'b0; rxSop = 1'b0; rxEop = 1'b0; rxMod = 3'd0; rxData = '0;
    end
  endtask

  // kind: 0 clean, 1 body data flip, 2 no SOP, 3 early EOP, 4 late EOP,
  //       5 wrong byte count, 6 header flip, 7 clean with stall cycles
  task automatic sendFrame(input int len, input int kind);
    int rem, nb, cnt, modv;
    logic [63:0] w;
    logic [2:0]  m;
    rem = len - 2;
    nb  = (rem + 7) / 8;
    beat(kind != 2, 1'b0, 3'd0, {48'h000001020304, 16'h0000});
    if (kind == 7) idle(2);
    w = {32'h05060708, 16'h88B5, 16'hBEEF};
    if (kind == 6) w = w ^ (64'h1 << 20);
    beat(1'b0, 1'b0, 3'd0, w);
    for (int k = 0; k < nb; k++) begin
      cnt = rem - 8 * k;
      w = {8{8'(cnt >> 3)}};
      if (kind == 1 && k == 1) w = w ^ 64'hFF;
      if (kind == 7 && k == 2) idle(3);
      if (k == nb - 1) begin
        modv = rem % 8;
        if (modv != 0)
          for (int j = modv; j < 8; j++) w[63-8*j -: 8] = 8'hA5;  // R6 junk lanes
        m = 3'(modv);
        if (kind == 5) m = m ^ 3'd1;
        if (kind == 3) break;
        beat(1'b0, kind != 4, m, w);
      end else begin
        beat(1'b0, (kind == 3) && (k == nb - 2), 3'd0, w);
      end
    end
    if (kind == 4) beat(1'b0, 1'b1, 3'd0, 64'h0);
    idle(20);
  endtask

  function automatic int kindFor(input int i);
    if (i % 3 == 2) return 1 + ((i / 3) % 6);
    if (i % 3 == 1) return 7;
    return 0;
  endfunction

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 goodCount", int'(goodCount), 0);
    check("R1 badCount", int'(badCount), 0);
    check("R1 errSticky", int'(errSticky), 0);
    check("R1 done", int'(done), 0);

    // R2 R3 R4 R5 R6 R7 R8 R9 R10 R11: sweep every length
    for (int len = MIN_LEN; len <= MAX_LEN; len++) begin
      int kind;
      kind = kindFor(len - MIN_LEN);
      sendFrame(len, kind);
      if (kind == 0 || kind == 7) expGood++;
      else                        expBad++;
      check($sformatf("R8 goodCount len %0d kind %0d", len, kind), int'(goodCount), expGood);
      check($sformatf("R9 badCount len %0d kind %0d", len, kind), int'(badCount), expBad);
      check($sformatf("R9 errSticky len %0d", len), int'(errSticky), int'(expBad > 0));
      check($sformatf("R12 done len %0d", len), int'(done), int'(len == MAX_LEN));
    end

    // R12: traffic after done is ignored
    sendFrame(MIN_LEN, 0);
    sendFrame(MIN_LEN + 1, 2);
    check("R12 goodCount frozen", int'(goodCount), expGood);
    check("R12 badCount frozen", int'(badCount), expBad);
    check("R12 done held", int'(done), 1);

    summary();
  end

endmodule